// File: doc/BRIEF.md
# Data Object Exchange Mailbox Register Block

This block is the device side of a data object exchange mailbox. A host reaches it through a simple 32-bit configuration read/write port. The host builds a request object one dword at a time in a write mailbox register, then writes GO to the control register. The block checks the object against the length in its header and streams it to a local responder. The responder streams the response dwords back. They are queued until the host drains them through a read mailbox register, where a read shows the current dword and a write acknowledges it.

The register window holds a capabilities word, a control word, a status word and the two mailbox registers. Status reports busy, a sticky error, a data-object-ready flag and a write-one-to-clear interrupt flag. An interrupt request is a single-cycle pulse. Abort returns the mailbox to idle in one cycle, clears every exchange in flight and empties both queues. Abort also serves as the reset step before first use.

Both data paths towards the responder use valid/ready. On the request stream the block holds `req_valid`, `req_data` and `req_last` steady until `req_ready` is seen high at a clock edge. On the response stream a dword moves only on an edge where `rsp_valid` and `rsp_ready` are both high. The block lowers `rsp_ready` while its response queue is full or while it is not expecting a response. The responder is expected to hold its dword until it is accepted.

Top module: `objx_mailbox`

## Requirements
- R1: After reset, the control and status registers read 0, the read mailbox reads 0, `req_valid` is 0 and `irq_pulse` is 0.
- R2: Request dwords are written at offset 0x10. The object length in dwords is taken from bits 17:0 of the second dword written. On a valid GO (control bit 31 at offset 0x08), exactly that many dwords go out on the request stream, in write order, with `req_last` high only on the final one. Any surplus dwords are discarded.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_data` does not change on the next cycle.
- R4: A GO is rejected when fewer dwords are queued than the declared length, or when the length is below 2. A rejected GO sets error (status bit 2) and discards the queued request, and nothing is sent. Error stays set until an abort, and further GO writes are ignored while it is set.
- R5: Status bit 0 (busy) is 1 from an accepted GO until the last response dword is queued. Writes to the write mailbox while busy are ignored.
- R6: Response dwords are accepted only while the block is waiting for a response. Accepting the dword flagged `rsp_last` sets data-object-ready (status bit 31) and clears busy.
- R7: A read at offset 0x14 returns the oldest queued response dword, or 0 when the queue is empty, and consumes nothing. Any write to 0x14 advances to the next dword. Data-object-ready clears when the final dword is acknowledged.
- R8: Interrupt status (status bit 1) is set by a rising data-object-ready, by a rising error, and by completion of an abort. Writing 1 to status bit 1 clears it, and a set in the same cycle takes precedence over the clear.
- R9: Interrupt enable is control bit 1 and reads back there. Each event of R8 yields a one-cycle `irq_pulse` only when interrupt enable is 1, with the value written in the same control write taking effect for that write's abort.
- R10: Abort (control bit 0) returns busy, error and data-object-ready to 0 in the next cycle. It empties both queues, lowers `rsp_ready` and pulses `xchg_abort` for the responder.
- R11: The capabilities register at offset 0x04 reports interrupt support in bit 0 and the interrupt message number in bits 11:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 8 | Byte offset from the capability base |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid in the cycle of `cfg_rd`, otherwise 0 |
| req_valid | output | 1 | Request dword available to the responder |
| req_ready | input | 1 | Responder takes the request dword |
| req_data | output | 32 | Request dword |
| req_last | output | 1 | Final dword of the request object |
| rsp_valid | input | 1 | Responder offers a response dword |
| rsp_ready | output | 1 | Block accepts a response dword |
| rsp_data | input | 32 | Response dword |
| rsp_last | input | 1 | Final dword of the response object |
| xchg_abort | output | 1 | One-cycle notice that the exchange was aborted |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The assertions assume that the responder holds `rsp_valid`, `rsp_data` and `rsp_last` until they are accepted. They also assume it flags exactly one final dword per response, that responses fit in the response queue, and that the host never asserts read and write in the same cycle. The stimulus keeps to these rules. Every response in the sweep is at most four dwords against a depth of eight. Response dwords are driven between edges and are released only after an edge where `rsp_ready` was high. Request back-pressure is exercised by a fixed ready pattern that drops `req_ready` one cycle in three. Surplus request dwords are kept within the request queue depth.

// File: rtl/objx_pkg.sv
package objx_pkg;
  localparam int CFG_AW = 8;
  localparam int CFG_DW = 32;

  localparam logic [CFG_AW-1:0] OFS_CAPS = 8'h04;
  localparam logic [CFG_AW-1:0] OFS_CTRL = 8'h08;
  localparam logic [CFG_AW-1:0] OFS_STAT = 8'h0C;
  localparam logic [CFG_AW-1:0] OFS_WMB  = 8'h10;
  localparam logic [CFG_AW-1:0] OFS_RMB  = 8'h14;

  localparam int CTL_ABORT_BIT = 0;
  localparam int CTL_IEN_BIT   = 1;
  localparam int CTL_GO_BIT    = 31;

  localparam int STA_BUSY_BIT = 0;
  localparam int STA_INT_BIT  = 1;
  localparam int STA_ERR_BIT  = 2;
  localparam int STA_DOR_BIT  = 31;

  localparam int CAP_MSG_LSB = 1;
  localparam int CAP_MSG_W   = 11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_RECV = 2'd2
  } objx_state_e;
endpackage

// File: rtl/objx_fifo.sv
module objx_fifo #(
  parameter  int WIDTH = 32,
  parameter  int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic             do_push, do_pop;

  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign rdata   = mem[rd_q];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else if (clr) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_q] <= wdata;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |-> !full);  // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> !empty);  // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));  // R6
endmodule

// File: rtl/objx_ctrl.sv
module objx_ctrl
  import objx_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int LEN_W   = 18,
  parameter bit INT_SUP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_abort,
  input  logic             ctl_go,
  input  logic             ctl_ien,
  input  logic             sts_w1c,
  input  logic [CNT_W-1:0] req_count,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_fire,
  input  logic             rsp_fire_last,
  input  logic             rsp_final_ack,
  output logic             busy,
  output logic             err,
  output logic             dor,
  output logic             int_sts,
  output logic             int_en,
  output logic             irq,
  output logic             sending,
  output logic             receiving,
  output logic             req_last,
  output logic             req_clr,
  output logic             rsp_clr,
  output logic             abort_now
);
  objx_state_e      state_q, state_d;
  logic [LEN_W-1:0] sent_q;
  logic             go_w, have_obj, go_ok, go_bad;
  logic             err_rise, dor_rise, evt, ien_d;

  assign abort_now = ctl_wr & ctl_abort;
  assign go_w      = ctl_wr & ctl_go & ~ctl_abort;
  assign have_obj  = (req_count >= CNT_W'(2)) && (req_len >= LEN_W'(2)) &&
                     ({{(LEN_W-CNT_W){1'b0}}, req_count} >= req_len);
  assign go_ok     = go_w & (state_q == ST_IDLE) & ~err & have_obj;
  assign go_bad    = go_w & (state_q == ST_IDLE) & ~go_ok;

  assign busy      = (state_q != ST_IDLE);
  assign sending   = (state_q == ST_SEND);
  assign receiving = (state_q == ST_RECV);
  assign req_last  = (sent_q == req_len - LEN_W'(1));
  assign req_clr   = abort_now | go_bad | (req_fire & req_last);
  assign rsp_clr   = abort_now;

  assign err_rise  = go_bad & ~err;
  assign dor_rise  = rsp_fire_last & ~dor & ~abort_now;
  assign evt       = abort_now | err_rise | dor_rise;

  generate
    if (INT_SUP) begin : g_int
      assign ien_d = ctl_wr ? ctl_ien : int_en;
    end else begin : g_noint
      logic unused_ien;
      assign unused_ien = ctl_ien;
      assign ien_d = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go_ok) state_d = ST_SEND;
      ST_SEND: if (req_fire && req_last) state_d = ST_RECV;
      ST_RECV: if (rsp_fire_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (abort_now) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sent_q  <= '0;
      err     <= 1'b0;
      dor     <= 1'b0;
      int_sts <= 1'b0;
      int_en  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (abort_now || go_ok) sent_q <= '0;
      else if (req_fire)      sent_q <= sent_q + LEN_W'(1);
      if (abort_now)   err <= 1'b0;
      else if (go_bad) err <= 1'b1;
      if (abort_now)          dor <= 1'b0;
      else if (rsp_fire_last) dor <= 1'b1;
      else if (rsp_final_ack) dor <= 1'b0;
      if (evt)          int_sts <= 1'b1;
      else if (sts_w1c) int_sts <= 1'b0;
      int_en <= ien_d;
      irq    <= evt & ien_d;
    end
  end

  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    abort_now |=> (!busy && !err && !dor));  // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_en && int_sts));  // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !abort_now) |=> err);  // R4
  AST_LAST_ENDS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_last && !abort_now) |=> receiving);  // R2
  AST_DOR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire_last && !abort_now) |=> (dor && !busy));  // R6
endmodule

// File: rtl/objx_mailbox.sv
module objx_mailbox
  import objx_pkg::*;
#(
  parameter int REQ_DEPTH     = 8,
  parameter int RSP_DEPTH     = 8,
  parameter int LEN_W         = 18,
  parameter bit IRQ_SUPPORTED = 1'b1,
  parameter int IRQ_MSG_NUM   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [CFG_DW-1:0] req_data,
  output logic              req_last,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [CFG_DW-1:0] rsp_data,
  input  logic              rsp_last,
  output logic              xchg_abort,
  output logic              irq_pulse
);
  localparam int REQ_CW = $clog2(REQ_DEPTH + 1);
  localparam int RSP_CW = $clog2(RSP_DEPTH + 1);

  logic              wr_ctrl, wr_stat, wr_wmb, wr_rmb;
  logic              busy, err, dor, int_sts, int_en, sending, receiving;
  logic              req_clr, rsp_clr, req_push, req_fire, rsp_fire, rsp_ack;
  logic              req_empty, req_full, rsp_empty, rsp_full;
  logic [REQ_CW-1:0] req_count;
  logic [RSP_CW-1:0] rsp_count;
  logic [CFG_DW-1:0] rsp_head, caps_word, ctrl_word, stat_word;
  logic [LEN_W-1:0]  len_q;

  assign wr_ctrl = cfg_wr && (cfg_addr == OFS_CTRL);
  assign wr_stat = cfg_wr && (cfg_addr == OFS_STAT);
  assign wr_wmb  = cfg_wr && (cfg_addr == OFS_WMB);
  assign wr_rmb  = cfg_wr && (cfg_addr == OFS_RMB);

  assign req_push  = wr_wmb & ~busy & ~req_full;
  assign req_valid = sending & ~req_empty;
  assign req_fire  = req_valid & req_ready;
  assign rsp_ready = receiving & ~rsp_full;
  assign rsp_fire  = rsp_valid & rsp_ready;
  assign rsp_ack   = wr_rmb & ~rsp_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else if (req_push && req_count == REQ_CW'(1)) len_q <= cfg_wdata[LEN_W-1:0];
  end

  objx_fifo #(.WIDTH(CFG_DW), .DEPTH(REQ_DEPTH)) u_req_fifo (
    .clk(clk), .rst_n(rst_n), .clr(req_clr), .push(req_push), .wdata(cfg_wdata),
    .pop(req_fire), .rdata(req_data), .count(req_count), .empty(req_empty), .full(req_full)
  );

  objx_fifo #(.WIDTH(CFG_DW), .DEPTH(RSP_DEPTH)) u_rsp_fifo (
    .clk(clk), .rst_n(rst_n), .clr(rsp_clr), .push(rsp_fire), .wdata(rsp_data),
    .pop(rsp_ack), .rdata(rsp_head), .count(rsp_count), .empty(rsp_empty), .full(rsp_full)
  );

  objx_ctrl #(.CNT_W(REQ_CW), .LEN_W(LEN_W), .INT_SUP(IRQ_SUPPORTED)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(wr_ctrl),
    .ctl_abort(cfg_wdata[CTL_ABORT_BIT]),
    .ctl_go(cfg_wdata[CTL_GO_BIT]),
    .ctl_ien(cfg_wdata[CTL_IEN_BIT]),
    .sts_w1c(wr_stat & cfg_wdata[STA_INT_BIT]),
    .req_count(req_count), .req_len(len_q), .req_fire(req_fire),
    .rsp_fire_last(rsp_fire & rsp_last),
    .rsp_final_ack(rsp_ack & (rsp_count == RSP_CW'(1))),
    .busy(busy), .err(err), .dor(dor), .int_sts(int_sts), .int_en(int_en),
    .irq(irq_pulse), .sending(sending), .receiving(receiving), .req_last(req_last),
    .req_clr(req_clr), .rsp_clr(rsp_clr), .abort_now(xchg_abort)
  );

  always_comb begin
    caps_word = '0;
    caps_word[0] = IRQ_SUPPORTED;
    caps_word[CAP_MSG_LSB +: CAP_MSG_W] = CAP_MSG_W'(IRQ_MSG_NUM);
    ctrl_word = '0;
    ctrl_word[CTL_IEN_BIT] = int_en;
    stat_word = '0;
    stat_word[STA_BUSY_BIT] = busy;
    stat_word[STA_INT_BIT]  = int_sts;
    stat_word[STA_ERR_BIT]  = err;
    stat_word[STA_DOR_BIT]  = dor;
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_rd) begin
      unique case (cfg_addr)
        OFS_CAPS: cfg_rdata = caps_word;
        OFS_CTRL: cfg_rdata = ctrl_word;
        OFS_STAT: cfg_rdata = stat_word;
        OFS_RMB:  cfg_rdata = rsp_empty ? '0 : rsp_head;
        default:  cfg_rdata = '0;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !xchg_abort) |=> (req_valid && $stable(req_data)));  // R3
  AST_BUSY_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !req_clr) |=> (req_count <= $past(req_count)));  // R5
  AST_RSP_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |-> busy);  // R6
endmodule

// File: tb/test_objx_mailbox.sv
`timescale 1ns/1ps
module test_objx_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        req_valid, req_ready = 1'b1, req_last;
  logic [31:0] req_data;
  logic        rsp_valid = 1'b0, rsp_ready, rsp_last = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        xchg_abort, irq_pulse;

  int checks = 0, failures = 0;
  int got_n = 0, irq_n = 0, cyc = 0;
  bit bp_mode = 1'b0;
  bit done = 1'b0;
  logic [31:0] got_d [0:1023];
  logic        got_l [0:1023];

  localparam logic [7:0] A_CAPS = 8'h04, A_CTRL = 8'h08, A_STAT = 8'h0C,
                         A_WMB = 8'h10, A_RMB = 8'h14;

  always #10 clk = ~clk;

  objx_mailbox i_objx_mailbox (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_data(req_data), .req_last(req_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .xchg_abort(xchg_abort), .irq_pulse(irq_pulse)
  );

  always @(posedge clk) begin
    if (req_valid && req_ready && got_n < 1024) begin
      got_d[got_n] = req_data;
      got_l[got_n] = req_last;
      got_n = got_n + 1;
    end
    if (irq_pulse) irq_n = irq_n + 1;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    req_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    #2 d = cfg_rdata;
    cfg_rd = 1'b0;
  endtask

  function automatic logic [31:0] rsp_word(int l, int m, int i);
    return 32'h5A00_0000 + l * 256 + m * 16 + i;
  endfunction

  function automatic logic [31:0] req_word(int l, int i);
    if (i == 0) return 32'h00A5_0000 + l;
    if (i == 1) return l;
    return 32'hC0DE_0000 + l * 16 + i;
  endfunction

  task automatic send_rsp(int n, int l, int m, bit flag_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = rsp_word(l, m, i);
      rsp_last = flag_last && (i == n - 1);
      while (!rsp_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rsp_valid = 1'b0; rsp_last = 1'b0;
  endtask

  task automatic run_xchg(int l, int extra, int m, bit ien);
    int base, ic, bad;
    logic [31:0] v, v2;
    base = got_n;
    for (int i = 0; i < l; i++) cfg_write(A_WMB, req_word(l, i));
    for (int e = 0; e < extra; e++) cfg_write(A_WMB, 32'hEEEE_0000 + e);
    ic = irq_n;
    cfg_write(A_CTRL, 32'h8000_0000 | (32'(ien) << 1));
    while (got_n < base + l) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R2 request dword count", got_n - base, l);
    bad = 0;
    for (int i = 0; i < l; i++)
      if (got_d[base + i] !== req_word(l, i) || got_l[base + i] !== (i == l - 1)) bad++;
    check("R2 request order and last flag", bad, 0);
    cfg_read(A_STAT, v);
    check("R5 busy while waiting for response", v, 32'h1);
    cfg_write(A_WMB, 32'hDEAD_BEEF);
    send_rsp(m, l, m, 1'b1);
    repeat (2) @(negedge clk);
    cfg_read(A_STAT, v);
    check("R6 ready set, busy clear", v, 32'h8000_0002);
    check("R9 irq count after ready", irq_n, ic + int'(ien));
    bad = 0;
    for (int j = 0; j < m; j++) begin
      cfg_read(A_RMB, v);
      cfg_read(A_RMB, v2);
      if (v !== rsp_word(l, m, j) || v2 !== v) bad++;
      if (j == m - 1) begin
        cfg_read(A_STAT, v);
        if (v[31] !== 1'b1) bad++;
      end
      cfg_write(A_RMB, 32'h0);
    end
    check("R7 response read without consume, write advances", bad, 0);
    cfg_read(A_STAT, v);
    check("R7 ready clears on final ack", v, 32'h2);
    cfg_write(A_STAT, 32'h2);
    cfg_read(A_STAT, v);
    check("R8 interrupt status write-one-to-clear", v, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int ic, base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cfg_read(A_CTRL, v); check("R1 control after reset", v, 32'h0);
    cfg_read(A_STAT, v); check("R1 status after reset", v, 32'h0);
    cfg_read(A_RMB, v);  check("R1 read mailbox after reset", v, 32'h0);
    check("R1 req_valid after reset", {31'b0, req_valid}, 32'h0);
    check("R1 irq after reset", irq_n, 0);
    cfg_read(A_CAPS, v); check("R11 capabilities", v, 32'h0000_000B);

    ic = irq_n;
    cfg_write(A_CTRL, 32'h3);
    cfg_read(A_STAT, v); check("R10 reset abort leaves idle", v, 32'h2);
    cfg_read(A_CTRL, v); check("R9 enable reads back", v, 32'h2);
    repeat (2) @(negedge clk);
    check("R9 irq on abort", irq_n, ic + 1);
    cfg_write(A_STAT, 32'h2);

    for (int bp = 0; bp < 2; bp++) begin
      bp_mode = bp[0];
      for (int l = 2; l <= 6; l++)
        for (int ex = 0; ex < 2; ex++)
          for (int m = 1; m <= 4; m++)
            run_xchg(l, ex, m, (m % 2) == 1);
    end
    bp_mode = 1'b0;

    // R4: short object
    base = got_n; ic = irq_n;
    cfg_write(A_WMB, req_word(5, 0));
    cfg_write(A_WMB, 32'd5);
    cfg_write(A_WMB, 32'h1111_1111);
    cfg_write(A_CTRL, 32'h8000_0002);
    repeat (4) @(negedge clk);
    check("R4 nothing sent for short object", got_n, base);
    cfg_read(A_STAT, v); check("R4 error and interrupt set", v, 32'h6);
    check("R9 irq on error", irq_n, ic + 1);
    cfg_write(A_STAT, 32'h2);
    cfg_write(A_WMB, req_word(2, 0));
    cfg_write(A_WMB, 32'd2);
    cfg_write(A_CTRL, 32'h8000_0002);
    repeat (4) @(negedge clk);
    check("R4 GO ignored while error", got_n, base);
    cfg_read(A_STAT, v); check("R8 no new interrupt without error rise", v, 32'h4);
    check("R8 no irq without error rise", irq_n, ic + 1);
    cfg_write(A_CTRL, 32'h1);
    cfg_read(A_STAT, v); check("R10 abort clears error", v, 32'h2);
    check("R9 abort irq suppressed when disabled", irq_n, ic + 1);
    cfg_write(A_STAT, 32'h2);

    // R4: declared length below 2
    cfg_write(A_WMB, req_word(1, 0));
    cfg_write(A_WMB, 32'd1);
    cfg_write(A_CTRL, 32'h8000_0000);
    repeat (3) @(negedge clk);
    cfg_read(A_STAT, v); check("R4 length below two rejected", v, 32'h6);
    check("R4 nothing sent for tiny length", got_n, base);
    cfg_write(A_CTRL, 32'h1);
    cfg_write(A_STAT, 32'h2);

    // R10: abort with partial response queued
    base = got_n;
    cfg_write(A_WMB, req_word(2, 0));
    cfg_write(A_WMB, 32'd2);
    cfg_write(A_CTRL, 32'h8000_0000);
    while (got_n < base + 2) @(negedge clk);
    send_rsp(2, 2, 7, 1'b0);
    cfg_read(A_STAT, v); check("R6 no ready before last dword", v, 32'h1);
    cfg_write(A_CTRL, 32'h1);
    cfg_read(A_STAT, v); check("R10 abort mid exchange", v, 32'h2);
    cfg_read(A_RMB, v);  check("R10 response queue emptied", v, 32'h0);
    check("R10 rsp_ready low after abort", {31'b0, rsp_ready}, 32'h0);
    cfg_write(A_STAT, 32'h2);
    run_xchg(3, 1, 2, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule